// File: doc/BRIEF.md
# Timer-Paced Audio Sample Queue

This block is one streaming audio channel. Signed 8-bit samples arrive from a bus write port and are queued in a byte-wide first-in first-out store. Each bus write carries either a halfword (two samples) or a word (four samples), and the samples are queued starting with the least significant byte. Playback is paced by two external timer-overflow strobes. A select input chooses which strobe advances the channel, and a master enable gates both. Each accepted strobe moves the oldest queued sample into a held output register, where downstream mixing picks it up.

After each accepted strobe the block looks at how many samples remain. When half or less of the store is occupied, it sends a one-cycle refill pulse to the DMA engine. A flush input discards everything queued. The current occupancy is provided as an output.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset, sample_out is 0, fill_count is 0 and refill_req is 0.
- R2: A write with wr_en=1 and wr_word=0 queues two bytes, wr_data[7:0] first and then wr_data[15:8]. With wr_word=1 it queues four bytes in the order wr_data[7:0], [15:8], [23:16], [31:24].
- R3: A strobe is accepted only when timer_ovf[timer_sel] is 1, where timer_sel=0 picks bit 0 and timer_sel=1 picks bit 1. On the clock edge that accepts a strobe, the oldest sample moves into sample_out. The new value is visible from the next cycle and is held until the next accepted strobe.
- R4: While master_en is 0, timer strobes change neither sample_out nor fill_count.
- R5: refill_req pulses high for exactly one cycle, in the cycle after an accepted strobe. It pulses when the occupancy after removing one sample, counting no same-cycle write, is THRESH (16) or less. This includes a strobe that finds the store empty.
- R6: flush=1 empties the store on that edge. In the same cycle it overrides any write and any strobe: sample_out is left unchanged and no refill pulse follows.
- R7: Bytes are accepted in order until the store holds DEPTH (32) entries. Any further bytes of that write are dropped.
- R8: A strobe that finds the store empty leaves sample_out unchanged.
- R9: When a write and an accepted strobe fall in the same cycle, the removal frees its slot before the write's bytes are placed.
- R10: fill_count gives the occupancy and reflects each edge's changes from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master sound enable; gates the timer strobes |
| timer_sel | input | 1 | Selects which timer strobe paces the channel |
| timer_ovf | input | 2 | Overflow strobes from timer 0 (bit 0) and timer 1 (bit 1) |
| wr_en | input | 1 | Bus write into the sample queue |
| wr_word | input | 1 | 1: the write carries four bytes, 0: two bytes |
| wr_data | input | 32 | Write data, least significant byte queued first |
| flush | input | 1 | Discards all queued samples |
| sample_out | output | 8 | Held signed sample |
| refill_req | output | 1 | One-cycle DMA refill pulse |
| fill_count | output | 6 | Current occupancy |

## Verification
The bench fills the store to exactly 32 entries and then sends further halfword and word writes. A design that wrapped its write pointer here would overwrite the oldest samples, and the bench would read wrong bytes later. It steps pops across the 17-to-16 occupancy boundary, where an off-by-one comparison would move the refill pulse by one pop. It also strobes an empty store, where a design that popped anyway would output stale memory. Finally it combines a flush, a write and a strobe in one cycle, and a pop with a write in one cycle, to catch wrong priority or a space check made before the slot is freed.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

    localparam int SAMPLE_W  = 8;
    localparam int BUS_BYTES = 4;

    typedef logic [SAMPLE_W-1:0] sample_t;

    // number of bytes carried by a bus write
    localparam logic [2:0] HALF_BYTES = 3'd2;
    localparam logic [2:0] WORD_BYTES = 3'd4;

endpackage

// File: rtl/afifo_tick_sel.sv
module afifo_tick_sel (
    input  logic       master_en,
    input  logic       timer_sel,
    input  logic [1:0] timer_ovf,
    output logic       tick
);

    always_comb begin
        tick = master_en && timer_ovf[timer_sel];
    end

endmodule

// File: rtl/afifo_store.sv
module afifo_store
    import audio_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pop_req,
    input  logic                          flush,
    input  logic [2:0]                    push_n,
    input  logic [BUS_BYTES*SAMPLE_W-1:0] push_data,
    output sample_t                       head,
    output logic [CNT_W-1:0]              count,
    output logic                          pop_taken
);

    typedef struct packed {
        logic [DEPTH-1:0][SAMPLE_W-1:0] mem;
        logic [PTR_W-1:0]               rd;
        logic [PTR_W-1:0]               wr;
        logic [CNT_W-1:0]               cnt;
    } store_t;

    store_t st_d, st_q;

    logic             pop_ok;
    logic [CNT_W:0]   base_cnt;
    logic [CNT_W:0]   taken;
    logic [PTR_W-1:0] slot;

    always_comb begin
        st_d     = st_q;
        pop_ok   = pop_req && !flush && (st_q.cnt != '0);
        base_cnt = {1'b0, st_q.cnt} - (CNT_W+1)'(pop_ok);
        taken    = '0;
        slot     = st_q.wr;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            st_d.rd = st_q.rd + PTR_W'(pop_ok);
            for (int i = 0; i < BUS_BYTES; i++) begin
                if ((3'(i) < push_n) && ((base_cnt + taken) < (CNT_W+1)'(DEPTH))) begin
                    slot             = st_q.wr + PTR_W'(taken);
                    st_d.mem[slot]   = push_data[i*SAMPLE_W +: SAMPLE_W];
                    taken            = taken + 1'b1;
                end
            end
            st_d.wr  = st_q.wr + PTR_W'(taken);
            st_d.cnt = CNT_W'(base_cnt + taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head      = st_q.mem[st_q.rd];
    assign count     = st_q.cnt;
    assign pop_taken = pop_ok;

endmodule

// File: rtl/afifo_refill.sv
module afifo_refill #(
    parameter int DEPTH  = 32,
    parameter int THRESH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             flush,
    input  logic [CNT_W-1:0] count,
    output logic             req
);

    typedef struct packed {
        logic req;
    } refill_t;

    refill_t rf_d, rf_q;
    logic [CNT_W-1:0] left_after;

    always_comb begin
        rf_d       = rf_q;
        left_after = count - CNT_W'(count != '0);
        rf_d.req   = tick && !flush && (left_after <= CNT_W'(THRESH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign req = rf_q.req;

endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import audio_fifo_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int THRESH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          master_en,
    input  logic                          timer_sel,
    input  logic [1:0]                    timer_ovf,
    input  logic                          wr_en,
    input  logic                          wr_word,
    input  logic [BUS_BYTES*SAMPLE_W-1:0] wr_data,
    input  logic                          flush,
    output logic [SAMPLE_W-1:0]           sample_out,
    output logic                          refill_req,
    output logic [CNT_W-1:0]              fill_count
);

    typedef struct packed {
        sample_t sample;
    } out_t;

    out_t out_d, out_q;

    logic             tick;
    logic             pop_taken;
    sample_t          head;
    logic [2:0]       push_n;
    logic [CNT_W-1:0] count;

    afifo_tick_sel u_tick (
        .master_en (master_en),
        .timer_sel (timer_sel),
        .timer_ovf (timer_ovf),
        .tick      (tick)
    );

    always_comb begin
        push_n = !wr_en ? 3'd0 : (wr_word ? WORD_BYTES : HALF_BYTES);
    end

    afifo_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_req   (tick),
        .flush     (flush),
        .push_n    (push_n),
        .push_data (wr_data),
        .head      (head),
        .count     (count),
        .pop_taken (pop_taken)
    );

    afifo_refill #(.DEPTH(DEPTH), .THRESH(THRESH)) u_refill (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .flush (flush),
        .count (count),
        .req   (refill_req)
    );

    always_comb begin
        out_d = out_q;
        if (pop_taken) begin
            out_d.sample = head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample_out = out_q.sample;
    assign fill_count = count;

endmodule

// File: rtl/afifo_checker.sv
module afifo_checker #(
    parameter int DEPTH  = 32,
    parameter int THRESH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_en,
    input logic             timer_sel,
    input logic [1:0]       timer_ovf,
    input logic             wr_en,
    input logic             flush,
    input logic [7:0]       sample_out,
    input logic             refill_req,
    input logic [CNT_W-1:0] fill_count
);

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_ovf[timer_sel] |=> $stable(sample_out));

    a_r4_disabled_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> $stable(sample_out));

    a_r4_disabled_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !wr_en && !flush) |=> $stable(fill_count));

    a_r5_req_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> $past(master_en && timer_ovf[timer_sel] && !flush));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_count == '0));

    a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |=> $stable(sample_out));

endmodule

bind audio_sample_fifo afifo_checker #(.DEPTH(DEPTH), .THRESH(THRESH)) u_afifo_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_en  (master_en),
    .timer_sel  (timer_sel),
    .timer_ovf  (timer_ovf),
    .wr_en      (wr_en),
    .flush      (flush),
    .sample_out (sample_out),
    .refill_req (refill_req),
    .fill_count (fill_count)
);

// File: tb/test_audio_sample_fifo.sv
module test_audio_sample_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic        timer_sel = 1'b0;
    logic [1:0]  timer_ovf = 2'b00;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [31:0] wr_data = '0;
    logic        flush = 1'b0;
    logic [7:0]  sample_out;
    logic        refill_req;
    logic [5:0]  fill_count;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    audio_sample_fifo i_audio_sample_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_en  (master_en),
        .timer_sel  (timer_sel),
        .timer_ovf  (timer_ovf),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .wr_data    (wr_data),
        .flush      (flush),
        .sample_out (sample_out),
        .refill_req (refill_req),
        .fill_count (fill_count)
    );

    // Row: wr_en, wr_word, wr_data, ovf, sel, men, flush | exp sample, count, req | req id
    localparam int NV = 10;
    localparam logic [57:0] VEC [0:NV-1] = '{
        {1'b1,1'b0,32'h0000_8281,2'b00,1'b0,1'b1,1'b0, 8'h00,6'd2,1'b0, 4'd2}, // R2 half
        {1'b1,1'b1,32'h8685_8483,2'b00,1'b0,1'b1,1'b0, 8'h00,6'd6,1'b0, 4'd2}, // R2 word
        {1'b0,1'b0,32'h0,        2'b01,1'b0,1'b1,1'b0, 8'h81,6'd5,1'b1, 4'd3}, // R3 timer 0
        {1'b0,1'b0,32'h0,        2'b10,1'b0,1'b1,1'b0, 8'h81,6'd5,1'b0, 4'd3}, // R3 other timer
        {1'b0,1'b0,32'h0,        2'b10,1'b1,1'b1,1'b0, 8'h82,6'd4,1'b1, 4'd3}, // R3 timer 1
        {1'b0,1'b0,32'h0,        2'b11,1'b1,1'b0,1'b0, 8'h82,6'd4,1'b0, 4'd4}, // R4 disabled
        {1'b0,1'b0,32'h0,        2'b01,1'b1,1'b1,1'b0, 8'h82,6'd4,1'b0, 4'd3}, // R3 ignored
        {1'b1,1'b0,32'h0000_8887,2'b10,1'b1,1'b1,1'b0, 8'h83,6'd5,1'b1, 4'd9}, // R9 pop+write
        {1'b1,1'b0,32'h0000_1111,2'b10,1'b1,1'b1,1'b1, 8'h83,6'd0,1'b0, 4'd6}, // R6 flush wins
        {1'b0,1'b0,32'h0,        2'b10,1'b1,1'b1,1'b0, 8'h83,6'd0,1'b1, 4'd8}  // R8 empty pop
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic ww, input logic [31:0] d,
                         input logic [1:0] ovf, input logic sel, input logic men, input logic fl);
        @(negedge clk);
        wr_en = we; wr_word = ww; wr_data = d;
        timer_ovf = ovf; timer_sel = sel; master_en = men; flush = fl;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(1, 32'(sample_out), 32'h0, "R1 sample after reset");
        check(1, 32'(fill_count), 32'd0, "R1 count after reset");
        check(1, 32'(refill_req), 32'd0, "R1 req after reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][57], VEC[v][56], VEC[v][55:24], VEC[v][23:22],
                  VEC[v][21], VEC[v][20], VEC[v][19]);
            check(int'(VEC[v][3:0]), 32'(sample_out), 32'(VEC[v][18:11]), $sformatf("row %0d sample", v));
            check(int'(VEC[v][3:0]), 32'(fill_count), 32'(VEC[v][10:5]), $sformatf("row %0d count", v));
            check(int'(VEC[v][3:0]), 32'(refill_req), 32'(VEC[v][4]), $sformatf("row %0d req", v));
        end

        // R5: pulse lasts one cycle
        drive(1'b0, 1'b0, 32'h0, 2'b00, 1'b1, 1'b1, 1'b0);
        check(5, 32'(refill_req), 32'd0, "R5 pulse width");

        // R10/R7: fill to exactly DEPTH with bytes 0..31
        for (int k = 0; k < 8; k++) begin
            drive(1'b1, 1'b1, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}, 2'b00, 1'b1, 1'b1, 1'b0);
            check(10, 32'(fill_count), 32'(4*k+4), "R10 count while filling");
        end
        drive(1'b1, 1'b0, 32'h0000_EEEE, 2'b00, 1'b1, 1'b1, 1'b0);
        check(7, 32'(fill_count), 32'd32, "R7 write to full dropped");

        // two pops, then a word write that only partly fits
        drive(1'b0, 1'b0, 32'h0, 2'b10, 1'b1, 1'b1, 1'b0);
        check(3, 32'(sample_out), 32'h00, "R3 first sample after fill");
        check(5, 32'(refill_req), 32'd0, "R5 no req at 31");
        drive(1'b0, 1'b0, 32'h0, 2'b10, 1'b1, 1'b1, 1'b0);
        check(3, 32'(sample_out), 32'h01, "R3 second sample");
        drive(1'b1, 1'b1, 32'hDDCC_BBAA, 2'b00, 1'b1, 1'b1, 1'b0);
        check(7, 32'(fill_count), 32'd32, "R7 partial accept");

        // drain: pop k leaves 32-k, pulse first at k=16
        for (int k = 1; k <= 32; k++) begin
            drive(1'b0, 1'b0, 32'h0, 2'b10, 1'b1, 1'b1, 1'b0);
            if (k <= 30)
                check(7, 32'(sample_out), 32'(k + 1), "R7 order kept");
            else
                check(7, 32'(sample_out), (k == 31) ? 32'hAA : 32'hBB, "R7 accepted tail bytes");
            check(5, 32'(refill_req), (k >= 16) ? 32'd1 : 32'd0, "R5 threshold");
            check(10, 32'(fill_count), 32'(32 - k), "R10 count while draining");
        end

        // R8: empty pop holds last value
        drive(1'b0, 1'b0, 32'h0, 2'b10, 1'b1, 1'b1, 1'b0);
        check(8, 32'(sample_out), 32'hBB, "R8 empty pop holds");
        check(8, 32'(fill_count), 32'd0, "R8 count stays empty");

        finish_run();
    end

endmodule